// File: doc/BRIEF.md
# DRAM ECC Error Capture and Status

This block collects error events from the ECC correction path of a multi-channel DRAM controller and holds them for software. Each channel presents a correctable-error pulse, an uncorrectable-error pulse and the address (column, row, bank, rank) and syndrome of the access that failed. The block keeps a shared status word with one bit per error class. For every channel it also keeps a 64-bit log word that records the details of one failing access.

Capture follows a strict ranking. The first correctable error is recorded and held. A later uncorrectable error may replace a held correctable entry. A correctable error never replaces an uncorrectable one, and an uncorrectable entry is never replaced by a second one. Software reads the registers through a plain read port with combinational data. It clears error classes by writing ones to the status word. That clear also releases the matching class in every channel log, so capture is armed again. A single level output signals that an error is pending.

Top module: `ecc_err_capture`

## Requirements
- R1: Status bit 0 is set one clock after a correctable pulse on any channel, and bit 1 is set one clock after an uncorrectable pulse on any channel. Status bits 15:2 always read zero.
- R2: A write to address 0 clears each status bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0. A write to any other address leaves the status unchanged.
- R3: A channel log word has this layout: column in bits 63:48, row in 47:32, bank in 31:29, rank in 28:27, syndrome in 23:16, the uncorrectable flag in bit 1 and the correctable flag in bit 0. Bits 26:24 and 15:2 read zero.
- R4: A correctable error is recorded only if its channel log holds neither flag. A second correctable error leaves the recorded fields unchanged.
- R5: An uncorrectable error is recorded over a log that holds only a correctable entry. The log then carries the uncorrectable error's fields and has bit 1 set.
- R6: While a log's uncorrectable flag is set, no later error of either class changes its fields.
- R7: Writing 1 to status bit 0 or bit 1 also clears that flag in every channel log, and the log accepts a new capture from the next cycle.
- R8: An error that arrives in the same cycle as the clear of its class is kept. The status bit and log flag stay set, and the log may capture it at once.
- R9: The irq output is high exactly when status bit 0 or bit 1 is set.
- R10: Read address 0 returns the status word in bits 15:0. Address 1+c returns the log of channel c. Every other address returns zero. Channels capture independently of one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_evt | input | NUM_CH | Correctable-error pulse, one bit per channel |
| ue_evt | input | NUM_CH | Uncorrectable-error pulse, one bit per channel |
| err_col | input | NUM_CH*16 | Column address of the failing access, per channel |
| err_row | input | NUM_CH*16 | Row address of the failing access, per channel |
| err_bank | input | NUM_CH*3 | Bank of the failing access, per channel |
| err_rank | input | NUM_CH*2 | Rank of the failing access, per channel |
| err_synd | input | NUM_CH*8 | ECC syndrome, per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 16 | Register write data (write-one-to-clear at address 0) |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 64 | Register read data, combinational |
| irq | output | 1 | Error pending level |

## Verification
Two things can land in the same clock: a software clear of an error class and a fresh error event of that class or the other class. The bench provokes this with a sweep. It puts each log into one of four starting states (empty, correctable on both channels, uncorrectable on both, mixed). From each state it applies every combination of event pulses on both channels together with every write-one pattern. A model in the bench applies the clear first, then the events against the cleared occupancy. The bench compares the status, both log words and irq with that model. A long pseudo-random walk then covers interleavings that the sweep does not reach.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

  localparam int COL_W  = 16;
  localparam int ROW_W  = 16;
  localparam int BANK_W = 3;
  localparam int RANK_W = 2;
  localparam int SYND_W = 8;
  localparam int LOG_W  = 64;
  localparam int STAT_W = 16;

  typedef struct packed {
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [RANK_W-1:0] rank;
    logic [SYND_W-1:0] synd;
  } ecc_fields_t;

  // Log word layout: col | row | bank | rank | 3'b0 | synd | 14'b0 | ue | ce
  function automatic logic [LOG_W-1:0] ecc_pack_log(ecc_fields_t f, logic ue, logic ce);
    return {f.col, f.row, f.bank, f.rank, 3'b000, f.synd, 14'd0, ue, ce};
  endfunction

  // Decide whether a log loads new fields, given occupancy after any clear.
  function automatic logic ecc_log_take(logic ce_in, logic ue_in, logic kept_ce, logic kept_ue);
    return (ue_in && !kept_ue) || (ce_in && !kept_ue && !kept_ce);
  endfunction

endpackage

// File: rtl/ecc_status_reg.sv
module ecc_status_reg
  import ecc_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_ce,
  input  logic              any_ue,
  input  logic              clr_ce,
  input  logic              clr_ue,
  output logic [STAT_W-1:0] status
);

  logic [1:0] st_q;
  logic [1:0] st_next;

  // Clear first, then set: a same-cycle event survives the clear.
  assign st_next[0] = (st_q[0] & ~clr_ce) | any_ce;
  assign st_next[1] = (st_q[1] & ~clr_ue) | any_ue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 2'b00;
    else        st_q <= st_next;
  end

  assign status = {{(STAT_W-2){1'b0}}, st_q};

  AST_SET_UE: assert property (@(posedge clk) disable iff (!rst_n)
    any_ue |=> st_q[1]); // R1
  AST_SET_CE: assert property (@(posedge clk) disable iff (!rst_n)
    any_ce |=> st_q[0]); // R1
  AST_W1C_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ce && !any_ce) |=> !st_q[0]); // R2
  AST_W0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[0] && !clr_ce) |=> st_q[0]); // R2
  AST_CLR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ue && any_ue) |=> st_q[1]); // R8

endmodule

// File: rtl/ecc_log_chan.sv
module ecc_log_chan
  import ecc_cap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_in,
  input  logic             ue_in,
  input  ecc_fields_t      fields_in,
  input  logic             clr_ce,
  input  logic             clr_ue,
  output logic [LOG_W-1:0] log_word,
  output logic             log_load
);

  logic        held_ce;
  logic        held_ue;
  logic        kept_ce;
  logic        kept_ue;
  ecc_fields_t fields_q;

  assign kept_ce  = held_ce & ~clr_ce;
  assign kept_ue  = held_ue & ~clr_ue;
  assign log_load = ecc_log_take(ce_in, ue_in, kept_ce, kept_ue);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_ce  <= 1'b0;
      held_ue  <= 1'b0;
      fields_q <= '0;
    end else begin
      held_ce <= kept_ce | ce_in;
      held_ue <= kept_ue | ue_in;
      if (log_load) fields_q <= fields_in;
    end
  end

  assign log_word = ecc_pack_log(fields_q, held_ue, held_ce);

  AST_CE_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_in && !ue_in && (held_ce || held_ue) && !clr_ce && !clr_ue) |=> $stable(fields_q)); // R4
  AST_UE_OVER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_in && !held_ue) |=> (held_ue && fields_q == $past(fields_in))); // R5
  AST_UE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (held_ue && !clr_ue) |=> (held_ue && $stable(fields_q))); // R6
  AST_CLR_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ce && !ce_in) |=> !held_ce); // R7
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ce && ce_in) |=> held_ce); // R8

endmodule

// File: rtl/ecc_rd_mux.sv
module ecc_rd_mux
  import ecc_cap_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int LOG_BASE  = 1
) (
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic [STAT_W-1:0]             status,
  input  logic [NUM_CH-1:0][LOG_W-1:0]  logs,
  output logic [LOG_W-1:0]              rd_data
);

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(STAT_ADDR)) rd_data = {{(LOG_W-STAT_W){1'b0}}, status};
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == ADDR_W'(LOG_BASE + c)) rd_data = logs[c];
    end
  end

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        ce_evt,
  input  logic [NUM_CH-1:0]        ue_evt,
  input  logic [NUM_CH*COL_W-1:0]  err_col,
  input  logic [NUM_CH*ROW_W-1:0]  err_row,
  input  logic [NUM_CH*BANK_W-1:0] err_bank,
  input  logic [NUM_CH*RANK_W-1:0] err_rank,
  input  logic [NUM_CH*SYND_W-1:0] err_synd,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [STAT_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [LOG_W-1:0]         rd_data,
  output logic                     irq
);

  localparam int STAT_ADDR = 0;
  localparam int LOG_BASE  = 1;

  logic                      stat_wr;
  logic                      clr_ce;
  logic                      clr_ue;
  logic                      any_ce;
  logic                      any_ue;
  logic [STAT_W-1:0]         status;
  logic [NUM_CH-1:0][LOG_W-1:0] logs;
  logic [NUM_CH-1:0]         log_load;
  logic                      unused_wr_hi;

  assign stat_wr      = wr_en && (wr_addr == ADDR_W'(STAT_ADDR));
  assign clr_ce       = stat_wr && wr_data[0];
  assign clr_ue       = stat_wr && wr_data[1];
  assign unused_wr_hi = ^{wr_data[STAT_W-1:2], log_load};
  assign any_ce       = |ce_evt;
  assign any_ue       = |ue_evt;

  ecc_status_reg u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .any_ce (any_ce),
    .any_ue (any_ue),
    .clr_ce (clr_ce),
    .clr_ue (clr_ue),
    .status (status)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    ecc_fields_t fin;
    assign fin.col  = err_col [c*COL_W  +: COL_W];
    assign fin.row  = err_row [c*ROW_W  +: ROW_W];
    assign fin.bank = err_bank[c*BANK_W +: BANK_W];
    assign fin.rank = err_rank[c*RANK_W +: RANK_W];
    assign fin.synd = err_synd[c*SYND_W +: SYND_W];

    ecc_log_chan u_log (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_in     (ce_evt[c]),
      .ue_in     (ue_evt[c]),
      .fields_in (fin),
      .clr_ce    (clr_ce),
      .clr_ue    (clr_ue),
      .log_word  (logs[c]),
      .log_load  (log_load[c])
    );
  end

  ecc_rd_mux #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR),
    .LOG_BASE  (LOG_BASE)
  ) u_mux (
    .rd_addr (rd_addr),
    .status  (status),
    .logs    (logs),
    .rd_data (rd_data)
  );

  assign irq = status[0] | status[1];

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(any_ce || any_ue)); // R9
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(stat_wr)); // R9

endmodule

// File: tb/ecc_err_capture_tb.sv
module ecc_err_capture_tb_top;

  localparam int CLK_P = 10;
  localparam int NCH   = 2;
  localparam int AW    = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    ce_evt = '0;
  logic [NCH-1:0]    ue_evt = '0;
  logic [NCH*16-1:0] err_col = '0;
  logic [NCH*16-1:0] err_row = '0;
  logic [NCH*3-1:0]  err_bank = '0;
  logic [NCH*2-1:0]  err_rank = '0;
  logic [NCH*8-1:0]  err_synd = '0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [15:0]       wr_data = '0;
  logic [AW-1:0]     rd_addr = '0;
  logic [63:0]       rd_data;
  logic              irq;

  ecc_err_capture #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .err_col(err_col), .err_row(err_row), .err_bank(err_bank),
    .err_rank(err_rank), .err_synd(err_synd), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  // Reference state
  logic [1:0]  m_st;
  logic        m_ce [NCH];
  logic        m_ue [NCH];
  logic [15:0] m_col [NCH];
  logic [15:0] m_row [NCH];
  logic [2:0]  m_bank [NCH];
  logic [1:0]  m_rank [NCH];
  logic [7:0]  m_synd [NCH];

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  function automatic logic [63:0] exp_log(int c);
    logic [63:0] v;
    v = 64'(m_col[c]) * 64'h1_0000_0000_0000 + 64'(m_row[c]) * 64'h1_0000_0000
      + 64'(m_bank[c]) * 64'h2000_0000 + 64'(m_rank[c]) * 64'h800_0000
      + 64'(m_synd[c]) * 64'h1_0000 + 64'(m_ue[c]) * 2 + 64'(m_ce[c]);
    return v;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_reg(input logic [AW-1:0] a, output logic [63:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // Drive one cycle of stimulus (called just after a negedge), update model.
  task automatic step(input logic [1:0] ce, input logic [1:0] ue,
                      input logic we, input logic [AW-1:0] wa, input logic [15:0] wd);
    logic [15:0] c_col [NCH];
    logic [15:0] c_row [NCH];
    logic [2:0]  c_bank [NCH];
    logic [1:0]  c_rank [NCH];
    logic [7:0]  c_synd [NCH];
    logic [1:0]  clr;
    for (int c = 0; c < NCH; c++) begin
      logic [31:0] r1;
      logic [31:0] r2;
      r1 = rnd();
      r2 = rnd();
      c_col[c] = r1[31:16]; c_row[c] = r2[31:16];
      c_bank[c] = r1[10:8]; c_rank[c] = r2[12:11]; c_synd[c] = r1[7:0] ^ r2[7:0];
      err_col[c*16 +: 16] = c_col[c];
      err_row[c*16 +: 16] = c_row[c];
      err_bank[c*3 +: 3]  = c_bank[c];
      err_rank[c*2 +: 2]  = c_rank[c];
      err_synd[c*8 +: 8]  = c_synd[c];
    end
    ce_evt = ce; ue_evt = ue;
    wr_en = we; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    @(negedge clk);
    ce_evt = '0; ue_evt = '0; wr_en = 1'b0;
    clr = (we && wa == 0) ? wd[1:0] : 2'b00;
    // model: clear applies first, events then act on what remains
    for (int c = 0; c < NCH; c++) begin
      logic oc;
      logic ou;
      oc = m_ce[c] && !clr[0];
      ou = m_ue[c] && !clr[1];
      if ((ue[c] && !ou) || (ce[c] && !ue[c] && !ou && !oc)) begin
        m_col[c] = c_col[c]; m_row[c] = c_row[c]; m_bank[c] = c_bank[c];
        m_rank[c] = c_rank[c]; m_synd[c] = c_synd[c];
      end
      m_ce[c] = oc || ce[c];
      m_ue[c] = ou || ue[c];
    end
    m_st[0] = (m_st[0] && !clr[0]) || (ce != 0);
    m_st[1] = (m_st[1] && !clr[1]) || (ue != 0);
  endtask

  task automatic check_all(string tag);
    logic [63:0] d;
    read_reg(0, d);
    chk({tag, " R1 R2 status"}, d, {62'd0, m_st});
    chk({tag, " R9 irq"}, {63'd0, irq}, {63'd0, m_st[0] | m_st[1]});
    for (int c = 0; c < NCH; c++) begin
      read_reg(AW'(1 + c), d);
      chk($sformatf("%s R3 R10 log%0d", tag, c), d, exp_log(c));
    end
  endtask

  task automatic model_reset();
    m_st = 2'b00;
    for (int c = 0; c < NCH; c++) begin
      m_ce[c] = 0; m_ue[c] = 0; m_col[c] = 0; m_row[c] = 0;
      m_bank[c] = 0; m_rank[c] = 0; m_synd[c] = 0;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [63:0] snap;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("reset");

    // R3: directed layout check on channel 1 with known fields
    err_col[31:16] = 16'hA5C3; err_row[31:16] = 16'h0F1E;
    err_bank[5:3] = 3'd5; err_rank[3:2] = 2'd2; err_synd[15:8] = 8'h9D;
    ce_evt = 2'b10;
    @(posedge clk); @(negedge clk);
    ce_evt = '0;
    read_reg(2, d);
    chk("R3 layout", d, 64'hA5C3_0F1E_B000_0000 | 64'h0000_0000_009D_0000 | 64'h1);
    read_reg(1, d);
    chk("R10 channel0 untouched", d, 64'd0);
    // R10: unmapped addresses read zero
    for (int a = 3; a < 16; a++) begin
      read_reg(AW'(a), d);
      chk("R10 unmapped", d, 64'd0);
    end
    // R2: write to non-status address has no effect
    wr_en = 1; wr_addr = 2; wr_data = 16'hFFFF;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    read_reg(0, d);
    chk("R2 other addr ignored", d, 64'h1);
    read_reg(2, snap);
    chk("R2 log kept", snap, 64'hA5C3_0F1E_B09D_0001);
    // bring the model into line with the directed stimulus
    m_st = 2'b01; m_ce[1] = 1; m_col[1] = 16'hA5C3; m_row[1] = 16'h0F1E;
    m_bank[1] = 3'd5; m_rank[1] = 2'd2; m_synd[1] = 8'h9D;
    // R2: writing zero leaves status
    step(2'b00, 2'b00, 1, 0, 16'h0000);
    check_all("R2 write zero");
    // R7: clear rearms
    step(2'b00, 2'b00, 1, 0, 16'hFFFF);
    check_all("R7 clear all");

    // Exhaustive sweep: start state x events x clear pattern
    for (int s = 0; s < 4; s++) begin
      for (int ev = 0; ev < 16; ev++) begin
        for (int cl = 0; cl < 4; cl++) begin
          step(2'b00, 2'b00, 1, 0, 16'h0003);
          case (s)
            1: step(2'b11, 2'b00, 0, 0, 0);
            2: step(2'b00, 2'b11, 0, 0, 0);
            3: step(2'b01, 2'b10, 0, 0, 0);
            default: ;
          endcase
          step(ev[1:0], ev[3:2], 1, 0, 16'(cl));
          check_all("sweep R4 R5 R6 R7 R8");
        end
      end
    end

    // Random walk
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic [1:0]  ce;
      logic [1:0]  ue;
      r = rnd();
      ce = r[17:16] & r[19:18];
      ue = r[21:20] & r[23:22] & r[25:24];
      step(ce, ue, r[27:26] == 0, AW'(r[29:28] & {2{r[30]}}), {14'(r[15:2]), r[1:0]});
      check_all("random R4 R5 R6 R8");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule